// File: doc/BRIEF.md
# Packet Receive DMA Channel

This channel moves 16-bit words delivered by a serial receiver into a buffer in word-addressed memory. The buffer is not held in channel registers. It is described by a control block in memory: the word at offset 2 is the next write address and the word at offset 3 is the buffer end. Software writes the control block and issues a start command with its base address. The channel checks the length, arms the receiver, and stores each word as it arrives. After each store it writes the advanced pointer back into the control block.

A packet ends when its last-flagged word is handled, when a word arrives with no room left, or at once when the buffer is empty at start. The channel then posts a status word at control block offset 8. The posted word is the status code ANDed with the hardware status input. The channel then reads the word at offset 9 and ORs it into a pending-interrupt register. A separately loaded discard mode makes the channel accept and drop words without touching memory, while still ending on the last word.

The controller is one state machine. Its states are:
- IDLE: waits for start.
- RD_PTR: reads offset 2.
- RD_END: reads offset 3 and latches the pointer.
- EVAL: compares the pointer with the end address.
- ARMED: the receiver is enabled.
- STORE: writes the data word.
- UPD_PTR: writes back pointer+1.
- POST_WR: writes the status.
- POST_RD: reads offset 9.
- POST_OR: merges the interrupt bits.

Its transitions are:
- IDLE goes to RD_PTR on start.
- RD_PTR goes to RD_END, and RD_END goes to EVAL.
- EVAL goes to POST_WR when the pointer equals the end. Otherwise it goes to STORE when handling a word, or to ARMED when handling a start.
- ARMED goes to RD_PTR on a word in normal mode. In discard mode a word keeps it in ARMED, or sends it to POST_WR if the word is last.
- STORE goes to UPD_PTR.
- UPD_PTR goes to POST_WR after a last word, or back to ARMED otherwise.
- POST_WR goes to POST_RD, then POST_OR, then IDLE.

Top module: `rxdma_chan`

## Requirements
- R1: After reset the channel is idle: no memory strobe, receiver not armed, interrupt bits all zero.
- R2: On start, the channel reads control block offsets 2 and 3. If they are equal, it does not arm and it posts code 16'h03FF (zero-length).
- R3: On start with pointer not equal to end, rx_arm_o goes high and no memory write takes place.
- R4: A word received in normal mode is written at the current pointer. Pointer+1 is then written to offset 2 in the next cycle, and the channel re-arms unless the word was last.
- R5: A word arriving while the pointer equals the end is not written to memory, and code 16'h02FF (overflow) is posted.
- R6: After the last-flagged word is stored and the pointer is updated, code 16'h01FF (done) is posted.
- R7: In discard mode received words cause no memory access and leave the pointer unchanged. A last-flagged word posts 16'h01FF.
- R8: The posted status is written at control block offset 8 and equals the code bitwise ANDed with hw_status_i.
- R9: The cycle after the status write, the word at offset 9 is read and ORed into irq_bits_o. Bits once set stay set.
- R10: After a post the channel is idle and ignores received words until the next start. While armed it makes no memory access.
- R11: Read and write strobes are never active in the same cycle.
- R12: setctl_i loads the discard mode from setctl_discard_i, and the mode persists across packets until reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start-reception command pulse |
| cb_base_i | input | 16 | Control block base address, taken with start_i |
| setctl_i | input | 1 | Load control mode |
| setctl_discard_i | input | 1 | Discard mode value loaded by setctl_i |
| rx_valid_i | input | 1 | Received word valid pulse |
| rx_last_i | input | 1 | Received word ends the packet |
| rx_data_i | input | 16 | Received word |
| hw_status_i | input | 16 | Hardware status bits ANDed into the posted code |
| rx_arm_o | output | 1 | Receiver enabled |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rd_o | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 16 | Memory read data, one cycle after mem_rd_o |
| irq_bits_o | output | 16 | Pending interrupt bits |

## Verification
The bench sweeps buffer lengths 0 to 3 against packet lengths 1 to 4. This separates the zero-length post, a packet that fits exactly or with room to spare (done), and a packet that overruns (overflow with the excess dropped). Each case has its own interrupt bit, so accumulation is visible. One hardware status pattern with cleared bits tells a true AND apart from a plain code write. Stray words after each post show the idle channel ignores the receiver. A discard sequence, a repeat of it, and a return to normal mode show that the mode drops data, leaves the pointer alone, and persists until reloaded.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RD_PTR, S_RD_END, S_EVAL, S_ARMED,
        S_STORE, S_UPD_PTR, S_POST_WR, S_POST_RD, S_POST_OR
    } rx_state_t;

    localparam int OFS_PTR  = 2;
    localparam int OFS_END  = 3;
    localparam int OFS_STAT = 8;
    localparam int OFS_IRQ  = 9;

    localparam logic [15:0] CODE_DONE = 16'o777;
    localparam logic [15:0] CODE_OVF  = 16'o1377;
    localparam logic [15:0] CODE_ZERO = 16'o1777;
endpackage

// File: rtl/rxdma_irq_acc.sv
module rxdma_irq_acc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] irq_o
);
    logic [DW-1:0] irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq_q <= '0;
        else if (load_i) irq_q <= irq_q | word_i;
    end

    assign irq_o = irq_q;

    // R9: pending bits never drop
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irq_q) & ~irq_q) == '0));
endmodule

// File: rtl/rxdma_ctl.sv
module rxdma_ctl
    import rxdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] cb_base_i,
    input  logic          setctl_i,
    input  logic          setctl_discard_i,
    input  logic          rx_valid_i,
    input  logic          rx_last_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic [DW-1:0] hw_status_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic          rx_arm_o,
    output logic          irq_load_o,
    output logic [DW-1:0] irq_word_o
);
    localparam logic [AW-1:0] A_PTR  = AW'(OFS_PTR);
    localparam logic [AW-1:0] A_END  = AW'(OFS_END);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_IRQ  = AW'(OFS_IRQ);

    rx_state_t     state_q, state_d;
    logic [AW-1:0] cb_q, ptr_q;
    logic [DW-1:0] word_q, code_q, code_d;
    logic          last_q, is_rx_q, discard_q;
    logic          take_word;

    assign take_word = (state_q == S_ARMED) && rx_valid_i;

    // next state
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_RD_PTR;
            S_RD_PTR:  state_d = S_RD_END;
            S_RD_END:  state_d = S_EVAL;
            S_EVAL: begin
                if (ptr_q == AW'(mem_rdata_i)) begin
                    state_d = S_POST_WR;
                    code_d  = is_rx_q ? DW'(CODE_OVF) : DW'(CODE_ZERO);
                end else begin
                    state_d = is_rx_q ? S_STORE : S_ARMED;
                end
            end
            S_ARMED: begin
                if (rx_valid_i) begin
                    if (!discard_q) begin
                        state_d = S_RD_PTR;
                    end else if (rx_last_i) begin
                        state_d = S_POST_WR;
                        code_d  = DW'(CODE_DONE);
                    end
                end
            end
            S_STORE:   state_d = S_UPD_PTR;
            S_UPD_PTR: begin
                if (last_q) begin
                    state_d = S_POST_WR;
                    code_d  = DW'(CODE_DONE);
                end else begin
                    state_d = S_ARMED;
                end
            end
            S_POST_WR: state_d = S_POST_RD;
            S_POST_RD: state_d = S_POST_OR;
            S_POST_OR: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cb_q      <= '0;
            ptr_q     <= '0;
            word_q    <= '0;
            code_q    <= '0;
            last_q    <= 1'b0;
            is_rx_q   <= 1'b0;
            discard_q <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            if (setctl_i) discard_q <= setctl_discard_i;
            if (state_q == S_IDLE && start_i) begin
                cb_q    <= cb_base_i;
                is_rx_q <= 1'b0;
                last_q  <= 1'b0;
            end
            if (take_word) begin
                word_q  <= rx_data_i;
                last_q  <= rx_last_i;
                is_rx_q <= 1'b1;
            end
            if (state_q == S_RD_END) ptr_q <= AW'(mem_rdata_i);
        end
    end

    // outputs
    always_comb begin
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        irq_load_o  = 1'b0;
        irq_word_o  = mem_rdata_i;
        rx_arm_o    = (state_q == S_ARMED);
        unique case (state_q)
            S_RD_PTR: begin mem_rd_o = 1'b1; mem_addr_o = cb_q + A_PTR; end
            S_RD_END: begin mem_rd_o = 1'b1; mem_addr_o = cb_q + A_END; end
            S_STORE: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = ptr_q;
                mem_wdata_o = word_q;
            end
            S_UPD_PTR: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = cb_q + A_PTR;
                mem_wdata_o = DW'(ptr_q + 1'b1);
            end
            S_POST_WR: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = cb_q + A_STAT;
                mem_wdata_o = code_q & hw_status_i;
            end
            S_POST_RD: begin mem_rd_o = 1'b1; mem_addr_o = cb_q + A_IRQ; end
            S_POST_OR: irq_load_o = 1'b1;
            default: ;
        endcase
    end

    // R11: one strobe at a time
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
    // R10: armed channel is silent on the memory port
    p_armed_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_arm_o |-> (!mem_rd_o && !mem_wr_o));
    // R4: data write is followed by write-back of address+1 to the pointer slot
    p_ptr_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STORE) |=> (mem_wr_o && mem_addr_o == cb_q + A_PTR
                                  && mem_wdata_o == DW'($past(mem_addr_o) + 1'b1)));
    // R9: status write is followed by a read of the next word
    p_post_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POST_WR) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + 1'b1));
    // R7: discard mode never stores data
    p_discard_nostore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_word && discard_q) |=> !mem_wr_o || state_q == S_POST_WR);
endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] cb_base_i,
    input  logic          setctl_i,
    input  logic          setctl_discard_i,
    input  logic          rx_valid_i,
    input  logic          rx_last_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic [DW-1:0] hw_status_i,
    output logic          rx_arm_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [DW-1:0] irq_bits_o
);
    logic          irq_load;
    logic [DW-1:0] irq_word;

    rxdma_ctl #(.AW(AW), .DW(DW)) u_ctl (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .cb_base_i        (cb_base_i),
        .setctl_i         (setctl_i),
        .setctl_discard_i (setctl_discard_i),
        .rx_valid_i       (rx_valid_i),
        .rx_last_i        (rx_last_i),
        .rx_data_i        (rx_data_i),
        .hw_status_i      (hw_status_i),
        .mem_rdata_i      (mem_rdata_i),
        .mem_addr_o       (mem_addr_o),
        .mem_wdata_o      (mem_wdata_o),
        .mem_rd_o         (mem_rd_o),
        .mem_wr_o         (mem_wr_o),
        .rx_arm_o         (rx_arm_o),
        .irq_load_o       (irq_load),
        .irq_word_o       (irq_word)
    );

    rxdma_irq_acc #(.DW(DW)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (irq_load),
        .word_i (irq_word),
        .irq_o  (irq_bits_o)
    );
endmodule

// File: tb/rxdma_chan_tb.sv
module rxdma_chan_tb;
    localparam logic [15:0] DONE = 16'h01FF, OVF = 16'h02FF, ZERO = 16'h03FF;
    localparam int BUF = 16;

    logic        clk = 0, rst_n = 0;
    logic        start = 0, setctl = 0, setdisc = 0;
    logic        rxv = 0, rxl = 0;
    logic [15:0] rxd = 0, hw = 16'hFFFF, cbase = 0;
    logic        arm, mrd, mwr;
    logic [15:0] maddr, mwdata, irq;
    logic [15:0] mrdata = 0;
    logic [15:0] mem [64];
    int          nchk = 0, nfail = 0;
    logic [15:0] exp_irq = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    rxdma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cb_base_i(cbase),
        .setctl_i(setctl), .setctl_discard_i(setdisc),
        .rx_valid_i(rxv), .rx_last_i(rxl), .rx_data_i(rxd), .hw_status_i(hw),
        .rx_arm_o(arm), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
        .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_rdata_i(mrdata), .irq_bits_o(irq)
    );

    always @(posedge clk) begin
        if (mwr) mem[maddr[5:0]] <= mwdata;
        if (mrd) mrdata <= mem[maddr[5:0]];
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        cyc(10);
    endtask

    task automatic send(input logic [15:0] d, input logic last);
        @(negedge clk); rxv = 1; rxd = d; rxl = last;
        @(negedge clk); rxv = 0; rxl = 0;
        cyc(12);
    endtask

    task automatic setmode(input logic disc);
        @(negedge clk); setctl = 1; setdisc = disc;
        @(negedge clk); setctl = 0;
    endtask

    task automatic init_cb(input int len, input logic [15:0] pat);
        for (int i = 0; i < 64; i++) mem[i] = 16'hA000 | 16'(i);
        mem[2] = 16'(BUF); mem[3] = 16'(BUF + len); mem[8] = 0; mem[9] = pat;
    endtask

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 arm", {15'b0, arm}, 16'h0);
        chk("R1 strobes", {14'b0, mrd, mwr}, 16'h0);
        chk("R1 irq", irq, 16'h0);
        @(negedge clk); rst_n = 1;
        cyc(2);
        chk("R1 arm after reset", {15'b0, arm}, 16'h0);
        setmode(0);

        for (int len = 0; len < 4; len++) begin
            for (int n = 1; n < 5; n++) begin
                logic [15:0] pat, code;
                int stored;
                pat = 16'(1) << (len * 4 + n - 1);
                hw  = (len == 2) ? 16'h0F3C : 16'hFFFF;
                init_cb(len, pat);
                do_start();
                if (len == 0) begin
                    chk("R2 zero-length not armed", {15'b0, arm}, 16'h0);
                    chk("R2/R8 zero-length status", mem[8], ZERO & hw);
                    exp_irq |= pat;
                    chk("R9 irq after zero-length", irq, exp_irq);
                end else begin
                    chk("R3 armed", {15'b0, arm}, 16'h1);
                    chk("R3 no write at start", mem[8], 16'h0);
                    for (int k = 0; k < n; k++) begin
                        send(16'h5000 + 16'(k), k == n - 1);
                        if (k < len) begin
                            chk("R4 data stored", mem[BUF + k], 16'h5000 + 16'(k));
                            chk("R4 pointer written", mem[2], 16'(BUF + k + 1));
                            if (k < n - 1)
                                chk("R4 re-armed", {15'b0, arm}, 16'h1);
                        end
                    end
                    stored = (n < len) ? n : len;
                    code   = (n <= len) ? DONE : OVF;
                    chk((n <= len) ? "R6/R8 done status" : "R5/R8 overflow status", mem[8], code & hw);
                    chk("R5 pointer final", mem[2], 16'(BUF + stored));
                    if (n > len)
                        chk("R5 overflow word dropped", mem[BUF + len], 16'hA000 | 16'(BUF + len));
                    exp_irq |= pat;
                    chk("R9 irq merged", irq, exp_irq);
                end
                // R10 stray word while idle
                mem[8] = 16'h1234;
                send(16'h7777, 1);
                chk("R10 idle ignores word: status", mem[8], 16'h1234);
                chk("R10 idle ignores word: not armed", {15'b0, arm}, 16'h0);
                chk("R10 idle ignores word: buffer", mem[BUF + len], 16'hA000 | 16'(BUF + len));
            end
        end

        // R7 / R12 discard mode
        hw = 16'hFFFF;
        setmode(1);
        init_cb(3, 16'h0000);
        do_start();
        send(16'h6001, 0);
        chk("R7 armed after discarded word", {15'b0, arm}, 16'h1);
        chk("R7 buffer untouched", mem[BUF], 16'hA000 | 16'(BUF));
        chk("R7 pointer untouched", mem[2], 16'(BUF));
        send(16'h6002, 0);
        send(16'h6003, 1);
        chk("R7 done status", mem[8], DONE);
        chk("R7 pointer still untouched", mem[2], 16'(BUF));
        chk("R7 buffer still untouched", mem[BUF + 1], 16'hA000 | 16'(BUF + 1));
        chk("R9 irq unchanged by zero word", irq, exp_irq);
        mem[8] = 0;
        do_start();
        send(16'h6004, 1);
        chk("R12 mode persists", mem[BUF], 16'hA000 | 16'(BUF));
        chk("R12 persist done status", mem[8], DONE);
        setmode(0);
        mem[8] = 0;
        do_start();
        send(16'h6005, 1);
        chk("R12 mode reloaded: stored", mem[BUF], 16'h6005);
        chk("R12 mode reloaded: pointer", mem[2], 16'(BUF + 1));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end
endmodule